// File: doc/BRIEF.md
# Transmit FIFO Threshold Controller

This block sits between a memory fetch engine and an Ethernet-style MAC transmitter. Each FIFO entry holds one 4-byte word, and an extra bit marks the last word of a frame. The fetch engine pushes words, and the MAC pulls them. The controller decides when a frame may start. A frame starts once occupancy reaches a programmable start level, or sooner when the whole frame (its end-of-frame word) is already buffered. Without that shortcut, short frames would never be sent.

A starve detector with hysteresis drives a fetch-priority request. The request turns on when occupancy falls to the starve level. It turns off only when occupancy climbs back to a separate, higher exit watermark. If the FIFO runs dry in the middle of a frame, the frame is aborted toward the MAC and a sticky underrun flag is set. The words of that frame that are still outstanding are then discarded, so the next frame starts clean.

All three levels are counted in entries and can be written by software. A write is staged, and it reaches the live comparators only at a frame boundary.

Top module: `txq_thresh_ctrl`

## Requirements
- R1: After reset, `fifo_empty` is 1, `fifo_full` is 0, `tx_valid` is 0, `urun_flag` is 0 and `fetch_hi_pri` is 1 (an empty FIFO is starved).
- R2: Words leave in the order they were written, each with its end-of-frame bit. `fifo_full` is 1 when DEPTH entries are held. A write while full is dropped and never appears at the output.
- R3: While no frame is in progress, `tx_valid` stays 0 until occupancy is at least the start level and no end-of-frame word is buffered. `tx_valid` rises one cycle after occupancy reaches the start level.
- R4: When an end-of-frame word is buffered, the frame starts one cycle later even if occupancy is below the start level.
- R5: `fetch_hi_pri` rises one cycle after occupancy is at or below the starve level. It stays 0 while occupancy is above that level and the block is not starved.
- R6: Once starved, `fetch_hi_pri` stays 1 until occupancy reaches the exit watermark. It falls one cycle after that.
- R7: If the FIFO is empty while a frame is in progress, `tx_abort` is 1 for exactly one cycle and `urun_flag` is set on the following edge.
- R8: After an abort, every remaining word of that frame, up to and including its end-of-frame word, is discarded without `tx_valid`. The next frame then starts with its own first word.
- R9: `urun_flag` is sticky and is cleared by a 1 on `urun_clr`. A new underrun in the same cycle as a clear leaves the flag set.
- R10: `cfg_sel` selects the level to write: 0 is the start level, 1 the starve level, 2 the exit watermark, and 3 writes nothing. A written value is staged and reaches the live comparators only while no frame is in progress. A write made mid-frame has no effect until that frame ends.
- R11: A write with a value above DEPTH is ignored. A staged set whose starve level is not below its exit watermark is not applied, and the live levels keep their values.
- R12: `tx_eof` marks the last word of a frame. After that word is taken, the block returns to idle, and the next frame is again gated by R3 and R4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Push one word from the fetch engine |
| wr_data | input | DATA_W | Word to push |
| wr_eof | input | 1 | Pushed word is the last of its frame |
| tx_ready | input | 1 | Transmitter takes the offered word |
| tx_valid | output | 1 | A word is offered to the transmitter |
| tx_data | output | DATA_W | Offered word |
| tx_eof | output | 1 | Offered word ends the frame |
| tx_abort | output | 1 | Current frame aborted by underrun |
| cfg_we | input | 1 | Level write strobe |
| cfg_sel | input | 2 | Level select (0 start, 1 starve, 2 exit) |
| cfg_wdata | input | CNT_W | Level value in entries |
| urun_clr | input | 1 | Clear the underrun flag |
| urun_flag | output | 1 | Sticky underrun indication |
| fetch_hi_pri | output | 1 | Raise memory fetch priority (starved) |
| fifo_full | output | 1 | FIFO holds DEPTH entries |
| fifo_empty | output | 1 | FIFO holds no entry |

## Verification
The bench builds the block with a depth of 16 entries, a start level of 8, a starve level of 4 and an exit watermark of 8. With these values, filling to full, crossing both watermarks in each direction, and draining to an underrun each take only a handful of pushes. Every boundary can therefore be probed cycle by cycle, one entry either side of each level. The same small depth lets the bench program start levels below and above the depth, and program an inverted starve and exit pair, so that the staging and rejection rules can be observed through `tx_valid` and `fetch_hi_pri`.

// File: rtl/txq_pkg.sv
package txq_pkg;

   typedef enum logic [1:0] {
      TXS_IDLE  = 2'd0,
      TXS_SEND  = 2'd1,
      TXS_DRAIN = 2'd2
   } txs_t;

   localparam logic [1:0] CFG_START  = 2'd0;
   localparam logic [1:0] CFG_STARVE = 2'd1;
   localparam logic [1:0] CFG_EXIT   = 2'd2;

endpackage

// File: rtl/txq_store.sv
module txq_store #(
   parameter int DATA_W = 32,
   parameter int DEPTH  = 512,
   parameter int CNT_W  = $clog2(DEPTH + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              push,
   input  logic [DATA_W-1:0] push_data,
   input  logic              push_eof,
   input  logic              pop,
   output logic [DATA_W-1:0] head_data,
   output logic              head_eof,
   output logic [CNT_W-1:0]  count,
   output logic [CNT_W-1:0]  eof_cnt,
   output logic              full,
   output logic              empty
);

   localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
   localparam logic [CNT_W-1:0] DEPTH_C = CNT_W'(DEPTH);
   localparam logic [CNT_W-1:0] ONE_C   = CNT_W'(1);

   logic [DATA_W:0] mem [DEPTH];
   logic [AW-1:0]   wptr, rptr, wnext, rnext;
   logic            push_ok, pop_ok, inc_eof, dec_eof;

   assign full    = (count == DEPTH_C);
   assign empty   = (count == '0);
   assign push_ok = push && !full;
   assign pop_ok  = pop && !empty;

   assign {head_eof, head_data} = mem[rptr];
   assign inc_eof = push_ok && push_eof;
   assign dec_eof = pop_ok && head_eof;

   // pointer advance: free wrap for power-of-two depths, compare otherwise
   generate
      if ((DEPTH & (DEPTH - 1)) == 0) begin : g_wrap_pow2
         assign wnext = wptr + AW'(1);
         assign rnext = rptr + AW'(1);
      end else begin : g_wrap_cmp
         assign wnext = (wptr == AW'(DEPTH - 1)) ? '0 : wptr + AW'(1);
         assign rnext = (rptr == AW'(DEPTH - 1)) ? '0 : rptr + AW'(1);
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (push_ok) mem[wptr] <= {push_eof, push_data};
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         wptr    <= '0;
         rptr    <= '0;
         count   <= '0;
         eof_cnt <= '0;
      end else begin
         if (push_ok) wptr <= wnext;
         if (pop_ok)  rptr <= rnext;
         case ({push_ok, pop_ok})
            2'b10:   count <= count + ONE_C;
            2'b01:   count <= count - ONE_C;
            default: count <= count;
         endcase
         case ({inc_eof, dec_eof})
            2'b10:   eof_cnt <= eof_cnt + ONE_C;
            2'b01:   eof_cnt <= eof_cnt - ONE_C;
            default: eof_cnt <= eof_cnt;
         endcase
      end
   end

   AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
      count <= DEPTH_C); // R2

   AST_EOF_WITHIN_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
      eof_cnt <= count); // R12

   AST_FULL_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
      full && push && !pop |=> full); // R2

endmodule

// File: rtl/txq_levels.sv
module txq_levels #(
   parameter int DEPTH      = 512,
   parameter int CNT_W      = $clog2(DEPTH + 1),
   parameter int START_RST  = 256,
   parameter int STARVE_RST = 128,
   parameter int EXIT_RST   = 256
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             we,
   input  logic [1:0]       sel,
   input  logic [CNT_W-1:0] wdata,
   input  logic             boundary,
   output logic [CNT_W-1:0] start_lvl,
   output logic [CNT_W-1:0] starve_lvl,
   output logic [CNT_W-1:0] exit_lvl
);
   import txq_pkg::*;

   localparam logic [CNT_W-1:0] DEPTH_C = CNT_W'(DEPTH);

   logic [CNT_W-1:0] stg_start, stg_starve, stg_exit;
   logic             wr_ok, set_ok;

   assign wr_ok  = we && (wdata <= DEPTH_C);
   assign set_ok = (stg_starve < stg_exit);

   // staged copies: written at any time
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         stg_start  <= CNT_W'(START_RST);
         stg_starve <= CNT_W'(STARVE_RST);
         stg_exit   <= CNT_W'(EXIT_RST);
      end else if (wr_ok) begin
         case (sel)
            CFG_START:  stg_start  <= wdata;
            CFG_STARVE: stg_starve <= wdata;
            CFG_EXIT:   stg_exit   <= wdata;
            default:    ;
         endcase
      end
   end

   // live copies: follow the staged set only between frames
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         start_lvl  <= CNT_W'(START_RST);
         starve_lvl <= CNT_W'(STARVE_RST);
         exit_lvl   <= CNT_W'(EXIT_RST);
      end else if (boundary && set_ok) begin
         start_lvl  <= stg_start;
         starve_lvl <= stg_starve;
         exit_lvl   <= stg_exit;
      end
   end

   AST_LIVE_ORDERED: assert property (@(posedge clk) disable iff (!rst_n)
      starve_lvl < exit_lvl); // R11

   AST_LIVE_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
      !boundary |=> $stable({start_lvl, starve_lvl, exit_lvl})); // R10

endmodule

// File: rtl/txq_starve.sv
module txq_starve #(
   parameter int CNT_W = 10
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [CNT_W-1:0] count,
   input  logic [CNT_W-1:0] starve_lvl,
   input  logic [CNT_W-1:0] exit_lvl,
   output logic             starved
);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         starved <= 1'b1;
      end else if (starved) begin
         if (count >= exit_lvl) starved <= 1'b0;
      end else begin
         if (count <= starve_lvl) starved <= 1'b1;
      end
   end

   AST_STARVE_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(starved) |-> $past(count) <= $past(starve_lvl)); // R5

   AST_STARVE_EXIT: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(starved) |-> $past(count) >= $past(exit_lvl)); // R6

endmodule

// File: rtl/txq_thresh_ctrl.sv
module txq_thresh_ctrl #(
   parameter int DATA_W     = 32,
   parameter int DEPTH      = 512,
   parameter int START_RST  = 256,
   parameter int STARVE_RST = 128,
   parameter int EXIT_RST   = 256,
   localparam int CNT_W     = $clog2(DEPTH + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [DATA_W-1:0] wr_data,
   input  logic              wr_eof,
   input  logic              tx_ready,
   output logic              tx_valid,
   output logic [DATA_W-1:0] tx_data,
   output logic              tx_eof,
   output logic              tx_abort,
   input  logic              cfg_we,
   input  logic [1:0]        cfg_sel,
   input  logic [CNT_W-1:0]  cfg_wdata,
   input  logic              urun_clr,
   output logic              urun_flag,
   output logic              fetch_hi_pri,
   output logic              fifo_full,
   output logic              fifo_empty
);
   import txq_pkg::*;

   initial begin
      assert (DATA_W >= 1) else $error("DATA_W must be at least 1");
      assert (DEPTH >= 2) else $error("DEPTH must be at least 2");
      assert (START_RST <= DEPTH) else $error("start level exceeds depth");
      assert (EXIT_RST <= DEPTH) else $error("exit watermark exceeds depth");
      assert (STARVE_RST < EXIT_RST) else $error("starve level must sit below exit watermark");
   end

   txs_t             st_q, st_d;
   logic [CNT_W-1:0] count, eof_cnt;
   logic [CNT_W-1:0] start_lvl, starve_lvl, exit_lvl;
   logic             head_eof, pop, start_ok, take_last;
   logic [DATA_W-1:0] head_data;

   txq_store #(.DATA_W(DATA_W), .DEPTH(DEPTH), .CNT_W(CNT_W)) u_store (
      .clk       (clk),
      .rst_n     (rst_n),
      .push      (wr_en),
      .push_data (wr_data),
      .push_eof  (wr_eof),
      .pop       (pop),
      .head_data (head_data),
      .head_eof  (head_eof),
      .count     (count),
      .eof_cnt   (eof_cnt),
      .full      (fifo_full),
      .empty     (fifo_empty)
   );

   txq_levels #(
      .DEPTH(DEPTH), .CNT_W(CNT_W),
      .START_RST(START_RST), .STARVE_RST(STARVE_RST), .EXIT_RST(EXIT_RST)
   ) u_levels (
      .clk        (clk),
      .rst_n      (rst_n),
      .we         (cfg_we),
      .sel        (cfg_sel),
      .wdata      (cfg_wdata),
      .boundary   (st_q == TXS_IDLE),
      .start_lvl  (start_lvl),
      .starve_lvl (starve_lvl),
      .exit_lvl   (exit_lvl)
   );

   txq_starve #(.CNT_W(CNT_W)) u_starve (
      .clk        (clk),
      .rst_n      (rst_n),
      .count      (count),
      .starve_lvl (starve_lvl),
      .exit_lvl   (exit_lvl),
      .starved    (fetch_hi_pri)
   );

   assign tx_valid  = (st_q == TXS_SEND) && !fifo_empty;
   assign tx_abort  = (st_q == TXS_SEND) && fifo_empty;
   assign tx_data   = head_data;
   assign tx_eof    = head_eof;
   assign pop       = ((st_q == TXS_SEND) && tx_ready && !fifo_empty)
                   || ((st_q == TXS_DRAIN) && !fifo_empty);
   assign take_last = pop && head_eof;
   assign start_ok  = !fifo_empty && ((count >= start_lvl) || (eof_cnt != '0));

   always_comb begin
      st_d = st_q;
      case (st_q)
         TXS_IDLE:  if (start_ok) st_d = TXS_SEND;
         TXS_SEND: begin
            if (fifo_empty)     st_d = TXS_DRAIN;
            else if (take_last) st_d = TXS_IDLE;
         end
         TXS_DRAIN: if (take_last) st_d = TXS_IDLE;
         default:   st_d = TXS_IDLE;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st_q      <= TXS_IDLE;
         urun_flag <= 1'b0;
      end else begin
         st_q <= st_d;
         if (tx_abort)      urun_flag <= 1'b1;
         else if (urun_clr) urun_flag <= 1'b0;
      end
   end

   AST_START_GATED: assert property (@(posedge clk) disable iff (!rst_n)
      tx_valid && $past(st_q == TXS_IDLE) |->
         ($past(count >= start_lvl) || $past(eof_cnt != '0))); // R3

   AST_ABORT_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
      tx_abort |=> urun_flag); // R7

   AST_ABORT_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
      tx_abort |=> !tx_abort); // R7

   AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      urun_flag && !urun_clr |=> urun_flag); // R9

   AST_DRAIN_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
      $past(tx_abort) |-> !tx_valid); // R8

endmodule

// File: tb/txq_thresh_ctrl_test.sv
module txq_thresh_ctrl_test;

   localparam int DATA_W = 32;
   localparam int DEPTH  = 16;
   localparam int CNT_W  = $clog2(DEPTH + 1);

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              wr_en = 1'b0;
   logic [DATA_W-1:0] wr_data = '0;
   logic              wr_eof = 1'b0;
   logic              tx_ready = 1'b0;
   logic              tx_valid, tx_eof, tx_abort;
   logic [DATA_W-1:0] tx_data;
   logic              cfg_we = 1'b0;
   logic [1:0]        cfg_sel = '0;
   logic [CNT_W-1:0]  cfg_wdata = '0;
   logic              urun_clr = 1'b0;
   logic              urun_flag, fetch_hi_pri, fifo_full, fifo_empty;

   int n_run = 0;
   int n_fail = 0;
   bit done = 1'b0;
   logic [DATA_W:0] exp_q [$];

   always #5 clk = ~clk;

   txq_thresh_ctrl #(
      .DATA_W(DATA_W), .DEPTH(DEPTH),
      .START_RST(8), .STARVE_RST(4), .EXIT_RST(8)
   ) uut (
      .clk(clk), .rst_n(rst_n),
      .wr_en(wr_en), .wr_data(wr_data), .wr_eof(wr_eof),
      .tx_ready(tx_ready), .tx_valid(tx_valid), .tx_data(tx_data),
      .tx_eof(tx_eof), .tx_abort(tx_abort),
      .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata),
      .urun_clr(urun_clr), .urun_flag(urun_flag),
      .fetch_hi_pri(fetch_hi_pri), .fifo_full(fifo_full), .fifo_empty(fifo_empty)
   );

   task automatic tick();
      @(posedge clk);
      #1;
   endtask

   task automatic chk(input string tag, input longint act, input longint exp);
      n_run++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
      end
   endtask

   task automatic push(input logic [DATA_W-1:0] d, input logic eof, input bit keep);
      wr_en = 1'b1; wr_data = d; wr_eof = eof;
      tick();
      wr_en = 1'b0; wr_eof = 1'b0;
      if (keep) exp_q.push_back({eof, d});
   endtask

   task automatic take(input string tag);
      logic [DATA_W:0] e;
      e = exp_q.pop_front();
      chk({tag, " tx_valid"}, tx_valid, 1);
      chk({tag, " word"}, {tx_eof, tx_data}, e);
      tx_ready = 1'b1;
      tick();
      tx_ready = 1'b0;
   endtask

   task automatic cfg(input logic [1:0] s, input int v);
      cfg_we = 1'b1; cfg_sel = s; cfg_wdata = CNT_W'(v);
      tick();
      cfg_we = 1'b0;
   endtask

   task automatic t_reset();
      chk("R1 empty", fifo_empty, 1);
      chk("R1 full", fifo_full, 0);
      chk("R1 tx_valid", tx_valid, 0);
      chk("R1 urun_flag", urun_flag, 0);
      chk("R1 hi_pri", fetch_hi_pri, 1);
   endtask

   task automatic t_frame();
      for (int i = 0; i < 7; i++) push(100 + i, 1'b0, 1);
      chk("R6 hi_pri below exit", fetch_hi_pri, 1);
      tick();
      chk("R3 no start at 7", tx_valid, 0);
      push(107, 1'b0, 1);
      chk("R3 start one cycle later", tx_valid, 0);
      chk("R6 hi_pri at exit edge", fetch_hi_pri, 1);
      tick();
      chk("R3 started at 8", tx_valid, 1);
      chk("R6 hi_pri released", fetch_hi_pri, 0);
      push(108, 1'b0, 1);
      push(109, 1'b1, 1);
      for (int i = 0; i < 10; i++) take("R12 frame");
      chk("R12 idle after eof", tx_valid, 0);
      chk("R12 empty after eof", fifo_empty, 1);
      tick();
      chk("R5 starved when empty", fetch_hi_pri, 1);
      for (int i = 0; i < 3; i++) push(150 + i, 1'b0, 1);
      tick(); tick();
      chk("R12 next frame gated", tx_valid, 0);
   endtask

   task automatic t_full();
      for (int i = 0; i < 13; i++) push(200 + i, (i == 12), 1);
      chk("R2 full", fifo_full, 1);
      chk("R2 not empty", fifo_empty, 0);
      push(32'hDEAD, 1'b1, 0);
      chk("R2 still full", fifo_full, 1);
      for (int i = 0; i < 16; i++) take("R2 order");
      chk("R2 dropped word absent", tx_valid, 0);
      chk("R2 empty after drain", fifo_empty, 1);
   endtask

   task automatic t_starve();
      for (int i = 0; i < 9; i++) push(300 + i, 1'b0, 1);
      chk("R6 out of starve", fetch_hi_pri, 0);
      for (int i = 0; i < 4; i++) take("R5 frame");
      tick();
      chk("R5 above starve level", fetch_hi_pri, 0);
      take("R5 frame");
      tick();
      chk("R5 entered at level", fetch_hi_pri, 1);
      for (int i = 0; i < 3; i++) push(320 + i, 1'b0, 1);
      chk("R6 hysteresis hold", fetch_hi_pri, 1);
      push(323, 1'b1, 1);
      chk("R6 exit one cycle later", fetch_hi_pri, 1);
      tick();
      chk("R6 exit at watermark", fetch_hi_pri, 0);
      for (int i = 0; i < 8; i++) take("R6 frame");
   endtask

   task automatic t_underrun();
      for (int i = 0; i < 9; i++) push(400 + i, 1'b0, 1);
      tick();
      for (int i = 0; i < 9; i++) take("R7 frame");
      chk("R7 abort", tx_abort, 1);
      chk("R7 flag not yet", urun_flag, 0);
      urun_clr = 1'b1;
      tick();
      urun_clr = 1'b0;
      chk("R9 set wins over clear", urun_flag, 1);
      chk("R7 abort single cycle", tx_abort, 0);
      push(500, 1'b0, 0);
      chk("R8 no valid in drain", tx_valid, 0);
      push(501, 1'b0, 0);
      push(502, 1'b1, 0);
      tick();
      chk("R8 drained", fifo_empty, 1);
      chk("R8 no valid", tx_valid, 0);
      tick();
      chk("R9 sticky", urun_flag, 1);
      push(600, 1'b0, 1);
      tick();
      chk("R4 one word no eof", tx_valid, 0);
      push(601, 1'b1, 1);
      tick();
      chk("R4 short frame starts", tx_valid, 1);
      take("R8 clean frame");
      take("R8 clean frame");
      urun_clr = 1'b1;
      tick();
      urun_clr = 1'b0;
      chk("R9 cleared", urun_flag, 0);
   endtask

   task automatic t_levels();
      cfg(2'd0, 2);
      tick();
      push(700, 1'b0, 1);
      push(701, 1'b0, 1);
      tick();
      chk("R10 new start level", tx_valid, 1);
      for (int i = 0; i < 8; i++) push(702 + i, 1'b0, 1);
      tick();
      chk("R10 out of starve", fetch_hi_pri, 0);
      cfg(2'd2, 12);
      cfg(2'd1, 10);
      tick(); tick();
      chk("R10 mid-frame write held", fetch_hi_pri, 0);
      push(710, 1'b1, 1);
      for (int i = 0; i < 11; i++) take("R10 frame");
      cfg(2'd0, 20);
      cfg(2'd1, 13);
      cfg(2'd3, 1);
      tick(); tick();
      for (int i = 0; i < 3; i++) push(800 + i, 1'b0, 1);
      chk("R11 oversize start ignored", tx_valid, 1);
      for (int i = 3; i < 12; i++) push(800 + i, (i == 11), 1);
      tick();
      chk("R11 exit at 12", fetch_hi_pri, 0);
      tick();
      chk("R11 inverted set not applied", fetch_hi_pri, 0);
      for (int i = 0; i < 12; i++) take("R11 frame");
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         n_fail++;
         n_run++;
         $display("FAIL watchdog: actual hung expected finish");
         $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
         $finish;
      end
   end

   initial begin
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;
      t_reset();
      tick();
      chk("R1 hi_pri holds", fetch_hi_pri, 1);
      t_frame();
      t_full();
      t_starve();
      t_underrun();
      t_levels();
      done = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

endmodule